// File: doc/BRIEF.md
# Audio Codec Link Output Frame Serializer

This block produces the outgoing half of a serial audio-codec link. It runs on the bit clock supplied by the codec. Each frame is 256 bit clocks long: a 16-bit tag phase followed by twelve 20-bit slots. The frame goes out on a single data line with the most significant bit first. A frame marker output is high during the tag phase and low for the rest of the frame.

Two request channels feed the frame, and each uses a valid and accept handshake. The first is a codec register access: a read/write flag, a 7-bit register index and 16 bits of write data. The second is a stereo PCM playback sample pair. Both channels are sampled only at the boundary between frames. A request raised part-way through a frame must be held by its source. It is taken at the next boundary, and the block confirms this with a one-cycle accept pulse.

The tag phase marks the whole frame as valid, and it also marks each slot as valid on its own. A register access fills the address and data slots. A sample pair fills the left and right playback slots. All other slots are sent as zeros.

Top module: `aclink_out_serializer`

## Requirements
- R1: A frame lasts 256 bit clocks. `sync` is high for the first 16 bit clocks of every frame and low for the remaining 240. The first frame begins at the first rising edge after reset is released.
- R2: Tag bit 15 (the first bit sent) is 1 exactly when at least one slot in the frame is flagged valid. The flag for slot k is tag bit 15-k, and it is 1 only when that slot carries data.
- R3: A frame carrying a register access has tag bits 14 and 13 set (slots 1 and 2). Tag bits 2, 1 and 0 are always 0, which selects the primary codec.
- R4: For a register access, slot 1 bit 19 is 1 for a read and 0 for a write. Slot 1 bits 18..12 hold the register index, and its bits 11..0 are 0.
- R5: For a register write, slot 2 bits 19..4 hold the write data and bits 3..0 are 0. For a register read, slot 2 is all zeros.
- R6: A frame carrying a sample pair has tag bits 12 and 11 set (slots 3 and 4). The left sample goes in slot 3 and the right sample in slot 4. Each sample is left-justified from bit 19, and the unused low bits are 0.
- R7: Slots 5 to 12 are always all zeros. Slots 1 to 4 are all zeros in a frame that carries no matching request.
- R8: Requests are sampled only on the edge that starts a frame. The matching accept output is high for exactly the first bit clock of that frame. It is never high at any other time, including while a request waits part-way through a frame.
- R9: Every field is sent most significant bit first. While reset is high, `sync`, `sdata_out` and both accept outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock from the codec; everything changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A register access is requested |
| cmd_read | input | 1 | 1 = register read, 0 = register write |
| cmd_index | input | 7 | Codec register index |
| cmd_wdata | input | 16 | Register write data |
| cmd_accept | output | 1 | One-cycle pulse: the access was placed in the frame now starting |
| pcm_valid | input | 1 | A playback sample pair is offered |
| pcm_left | input | PCM_W | Left playback sample |
| pcm_right | input | PCM_W | Right playback sample |
| pcm_accept | output | 1 | One-cycle pulse: the sample pair was placed in the frame now starting |
| sync | output | 1 | Frame marker, high during the tag phase |
| sdata_out | output | 1 | Serial frame data, MSB first |

## Verification
The assertions assume that a source keeps its valid signal and data steady until it sees the accept pulse, and then drops valid within the same frame. Under that assumption an accept can only follow a boundary at which valid was high. The stimulus follows this rule. Requests are driven only after the frame marker falls, so they never change at a boundary. Valid is dropped in the cycle after the accept pulse appears. Each frame is paired with the expected image that was queued before the frame began.

// File: rtl/aclink_out_pkg.sv
package aclink_out_pkg;
  localparam int TAG_W     = 16;
  localparam int SLOT_W    = 20;
  localparam int NUM_SLOTS = 12;
  localparam int FRAME_W   = TAG_W + SLOT_W * NUM_SLOTS;
  localparam int IDX_W     = 7;
  localparam int REG_W     = 16;

  // Tag word: bit 15 = any slot valid, bit 15-k = slot k valid, low 3 bits zero.
  function automatic logic [TAG_W-1:0] make_tag(input logic [NUM_SLOTS:1] slot_ok);
    logic [TAG_W-1:0] t;
    t = '0;
    t[TAG_W-1] = |slot_ok;
    for (int k = 1; k <= NUM_SLOTS; k++) t[TAG_W-1-k] = slot_ok[k];
    return t;
  endfunction

  // Address slot: read flag on top, index below it, rest zero.
  function automatic logic [SLOT_W-1:0] make_addr_slot(input logic rd,
                                                       input logic [IDX_W-1:0] idx);
    return {rd, idx, {(SLOT_W-1-IDX_W){1'b0}}};
  endfunction

  // Data slot: write data in the top 16 bits, zero on a read.
  function automatic logic [SLOT_W-1:0] make_data_slot(input logic rd,
                                                       input logic [REG_W-1:0] wd);
    return rd ? '0 : {wd, {(SLOT_W-REG_W){1'b0}}};
  endfunction
endpackage

// File: rtl/aclink_bit_timer.sv
module aclink_bit_timer
  import aclink_out_pkg::*;
#(
  parameter int CNT_W = $clog2(FRAME_W)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] bit_idx,
  output logic             frame_load,
  output logic             sync
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] TAG_END = CNT_W'(TAG_W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             sync_q;

  assign frame_load = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= LAST;
      sync_q <= 1'b0;
    end else begin
      cnt_q <= frame_load ? '0 : cnt_q + 1'b1;
      if (frame_load)
        sync_q <= 1'b1;
      else if (cnt_q == TAG_END)
        sync_q <= 1'b0;
    end
  end

  assign bit_idx = cnt_q;
  assign sync    = sync_q;
endmodule

// File: rtl/aclink_frame_builder.sv
module aclink_frame_builder
  import aclink_out_pkg::*;
#(
  parameter int PCM_W = 16
) (
  input  logic               cmd_valid,
  input  logic               cmd_read,
  input  logic [IDX_W-1:0]   cmd_index,
  input  logic [REG_W-1:0]   cmd_wdata,
  input  logic               pcm_valid,
  input  logic [PCM_W-1:0]   pcm_left,
  input  logic [PCM_W-1:0]   pcm_right,
  output logic [FRAME_W-1:0] frame
);
  localparam int PAD = SLOT_W - PCM_W;

  logic [NUM_SLOTS:1] slot_ok;
  logic [SLOT_W-1:0]  slot_word [1:NUM_SLOTS];

  always_comb begin
    slot_ok    = '0;
    slot_ok[1] = cmd_valid;
    slot_ok[2] = cmd_valid;
    slot_ok[3] = pcm_valid;
    slot_ok[4] = pcm_valid;
  end

  assign frame[FRAME_W-1 -: TAG_W] = make_tag(slot_ok);

  for (genvar k = 1; k <= NUM_SLOTS; k++) begin : g_slot
    if (k == 1) begin : g_addr
      assign slot_word[k] = cmd_valid ? make_addr_slot(cmd_read, cmd_index) : '0;
    end else if (k == 2) begin : g_data
      assign slot_word[k] = cmd_valid ? make_data_slot(cmd_read, cmd_wdata) : '0;
    end else if (k == 3) begin : g_left
      assign slot_word[k] = pcm_valid ? (SLOT_W'(pcm_left) << PAD) : '0;
    end else if (k == 4) begin : g_right
      assign slot_word[k] = pcm_valid ? (SLOT_W'(pcm_right) << PAD) : '0;
    end else begin : g_idle
      assign slot_word[k] = '0;
    end
    assign frame[FRAME_W-TAG_W-1-SLOT_W*(k-1) -: SLOT_W] = slot_word[k];
  end
endmodule

// File: rtl/aclink_shift_out.sv
module aclink_shift_out
  import aclink_out_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  output logic               sdata
);
  logic [FRAME_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst)       sh_q <= '0;
    else if (load) sh_q <= frame;
    else           sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
  end

  assign sdata = sh_q[FRAME_W-1];
endmodule

// File: rtl/aclink_out_serializer.sv
module aclink_out_serializer
  import aclink_out_pkg::*;
#(
  parameter int PCM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic             cmd_read,
  input  logic [6:0]       cmd_index,
  input  logic [15:0]      cmd_wdata,
  output logic             cmd_accept,
  input  logic             pcm_valid,
  input  logic [PCM_W-1:0] pcm_left,
  input  logic [PCM_W-1:0] pcm_right,
  output logic             pcm_accept,
  output logic             sync,
  output logic             sdata_out
);
  localparam int CNT_W = $clog2(FRAME_W);

  logic [CNT_W-1:0]   bit_idx;
  logic               frame_load;
  logic [FRAME_W-1:0] next_frame;
  logic               cmd_acc_q, pcm_acc_q;

  aclink_bit_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .bit_idx(bit_idx), .frame_load(frame_load), .sync(sync)
  );

  aclink_frame_builder #(.PCM_W(PCM_W)) u_build (
    .cmd_valid(cmd_valid), .cmd_read(cmd_read), .cmd_index(cmd_index),
    .cmd_wdata(cmd_wdata), .pcm_valid(pcm_valid), .pcm_left(pcm_left),
    .pcm_right(pcm_right), .frame(next_frame)
  );

  aclink_shift_out u_shift (
    .clk(clk), .rst(rst), .load(frame_load), .frame(next_frame), .sdata(sdata_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_acc_q <= 1'b0;
      pcm_acc_q <= 1'b0;
    end else begin
      cmd_acc_q <= frame_load & cmd_valid;
      pcm_acc_q <= frame_load & pcm_valid;
    end
  end

  assign cmd_accept = cmd_acc_q;
  assign pcm_accept = pcm_acc_q;
endmodule

// File: rtl/aclink_out_checks.sv
module aclink_out_checks
  import aclink_out_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] bit_idx,
  input logic             frame_load,
  input logic             sync,
  input logic             sdata_out,
  input logic             cmd_valid,
  input logic             cmd_accept,
  input logic             pcm_valid,
  input logic             pcm_accept
);
  a_r1_sync_at_start: assert property (@(posedge clk) disable iff (rst)
    frame_load |=> sync);

  a_r1_sync_drop: assert property (@(posedge clk) disable iff (rst)
    $fell(sync) |-> $past(bit_idx) == CNT_W'(TAG_W - 1));

  a_r8_cmd_accept: assert property (@(posedge clk) disable iff (rst)
    cmd_accept |-> $past(frame_load) && $past(cmd_valid));

  a_r8_pcm_accept: assert property (@(posedge clk) disable iff (rst)
    pcm_accept |-> $past(frame_load) && $past(pcm_valid));

  a_r3_low_tag_zero: assert property (@(posedge clk) disable iff (rst)
    (sync && bit_idx >= CNT_W'(TAG_W - 3)) |-> !sdata_out);

  a_r7_upper_slots_zero: assert property (@(posedge clk) disable iff (rst)
    (bit_idx >= CNT_W'(TAG_W + 4 * SLOT_W)) |-> !sdata_out);
endmodule

bind aclink_out_serializer aclink_out_checks #(.CNT_W(CNT_W)) u_checks (
  .clk(clk), .rst(rst), .bit_idx(bit_idx), .frame_load(frame_load), .sync(sync),
  .sdata_out(sdata_out), .cmd_valid(cmd_valid), .cmd_accept(cmd_accept),
  .pcm_valid(pcm_valid), .pcm_accept(pcm_accept)
);

// File: tb/tb_aclink_out_serializer.sv
`timescale 1ns/1ps
module tb_aclink_out_serializer;
  localparam int PCM_W = 16;

  logic clk = 0, rst = 1;
  logic cmd_valid = 0, cmd_read = 0, pcm_valid = 0;
  logic [6:0] cmd_index = '0;
  logic [15:0] cmd_wdata = '0;
  logic [PCM_W-1:0] pcm_left = '0, pcm_right = '0;
  logic cmd_accept, pcm_accept, sync, sdata_out;

  int checks = 0, fails = 0;
  logic [255:0] expq[$];
  bit done = 0;

  always #2 clk = ~clk;

  aclink_out_serializer #(.PCM_W(PCM_W)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
    .cmd_index(cmd_index), .cmd_wdata(cmd_wdata), .cmd_accept(cmd_accept),
    .pcm_valid(pcm_valid), .pcm_left(pcm_left), .pcm_right(pcm_right),
    .pcm_accept(pcm_accept), .sync(sync), .sdata_out(sdata_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Expected frame, built bit by bit from the requirements.
  function automatic logic [255:0] expect_frame(input bit cv, input bit rd,
      input logic [6:0] idx, input logic [15:0] wd, input bit pv,
      input logic [PCM_W-1:0] l, input logic [PCM_W-1:0] r);
    logic [255:0] f = '0;
    int base;
    if (cv || pv) f[255] = 1;
    if (cv) begin f[254] = 1; f[253] = 1; end
    if (pv) begin f[252] = 1; f[251] = 1; end
    if (cv) begin
      base = 239;               // slot 1 bit 19
      f[base] = rd;
      for (int i = 0; i < 7; i++) f[base-1-i] = idx[6-i];
      if (!rd) for (int i = 0; i < 16; i++) f[base-20-i] = wd[15-i];
    end
    if (pv) for (int i = 0; i < PCM_W; i++) begin
      f[199-i] = l[PCM_W-1-i];
      f[179-i] = r[PCM_W-1-i];
    end
    return f;
  endfunction

  // Monitor: pops the expected image at each frame start, captures 256 bits.
  initial begin
    logic [255:0] got, exp;
    bit have;
    int hi;
    forever begin
      @(posedge sync);
      have = (expq.size() > 0);
      if (have) exp = expq.pop_front();
      hi = 0;
      for (int i = 0; i < 256; i++) begin
        @(negedge clk);
        got[255-i] = sdata_out;
        if (sync) hi++;
      end
      if (have) begin
        check("R1 sync high count", hi, 16);
        check("R2 R3 tag", got[255:240], exp[255:240]);
        check("R4 slot1", got[239:220], exp[239:220]);
        check("R5 slot2", got[219:200], exp[219:200]);
        check("R6 R9 slot3", got[199:180], exp[199:180]);
        check("R6 R9 slot4", got[179:160], exp[179:160]);
        check("R7 slots5-12 zero", {31'b0, got[159:0] != 0}, 0);
      end
    end
  end

  task automatic run_frame(input bit cv, input bit rd, input logic [6:0] idx,
      input logic [15:0] wd, input bit pv, input logic [PCM_W-1:0] l,
      input logic [PCM_W-1:0] r);
    @(negedge sync);
    @(negedge clk);
    cmd_valid = cv; cmd_read = rd; cmd_index = idx; cmd_wdata = wd;
    pcm_valid = pv; pcm_left = l; pcm_right = r;
    expq.push_back(expect_frame(cv, rd, idx, wd, pv, l, r));
    repeat (4) begin
      @(negedge clk);
      check("R8 no accept mid-frame", {cmd_accept, pcm_accept}, 2'b00);
    end
    @(posedge sync);
    @(negedge clk);
    check("R8 accept at frame start", {cmd_accept, pcm_accept}, {cv, pv});
    cmd_valid = 0; pcm_valid = 0;
    @(negedge clk);
    check("R8 accept one cycle", {cmd_accept, pcm_accept}, 2'b00);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        check("R9 reset outputs", {sync, sdata_out, cmd_accept, pcm_accept}, 4'b0);
        rst = 0;
        @(negedge clk);
        check("R1 first frame starts", sync, 1);
        run_frame(1, 0, 7'h2C, 16'hBEEF, 0, '0, '0);
        run_frame(1, 1, 7'h7F, 16'hFFFF, 0, '0, '0);
        run_frame(0, 0, '0, '0, 1, 16'h8001, 16'h7FFE);
        run_frame(1, 0, 7'h01, 16'h1234, 1, 16'hA5A5, 16'h5A5A);
        run_frame(0, 0, 7'h55, 16'hFFFF, 0, 16'hFFFF, 16'hFFFF);
        run_frame(1, 1, 7'h40, 16'h0000, 1, 16'hFFFF, 16'h0001);
        wait (expq.size() == 0);
        repeat (300) @(negedge clk);
        done = 1;
      end
      begin
        repeat (20000) @(negedge clk);
        if (!done) begin
          checks++; fails++;
          $display("FAIL watchdog: actual timeout expected completion");
        end
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule